// File: doc/BRIEF.md
# Dual-Output Bus Driver with Pipelined Parity Check

This block takes a 12-bit input word and presents it on two output banks that always carry the same value. A mode input picks the data path. In buffer mode the input word goes straight to both banks within the same cycle. In register mode both banks show a holding register that loads on the rising clock edge. A hold input freezes the low eight bits of that register while the top four bits keep loading on every edge.

Parity is checked in both modes. The parity bit for a word arrives one cycle after the word itself. The result lands in an error register one edge after that. The error register loads only on edges where input bit index 10 is high. The error output is open drain: it pulls low on an error and is otherwise undriven.

A bidirectional parity pin lets two blocks check one wider word. A block with its parity drive control low puts its partial sum on the pin. A block with the control high reads the pin, either as the parity sense when used alone or as the partner's partial sum. An output-off input releases all data outputs and the error output, and has no effect on the internal registers. Tristate outputs are modelled as separate value and enable signals.

Top module: `pbus_drv`

## Requirements
- R1: With buf_mode=1, ya and yb both equal din in the same cycle.
- R2: With buf_mode=0, after an edge where hold_low=0 and rst=0, ya and yb both equal the din sampled at that edge.
- R3: After an edge where hold_low=1 and rst=0, bits [11:8] of the register take din[11:8] and bits [7:0] keep their previous value. The register is visible on ya/yb when buf_mode=0.
- R4: While out_off=1, y_oe=0 and err_oe=0. The holding and error registers keep loading, so their contents appear once out_off returns to 0.
- R5: Let D be the word sampled at edge k and P the par_in sampled at edge k+1. If din[10]=1 at edge k+1, the error register takes ^D ^ P ^ S, where S=par_pin_i if par_drive=1 and S=0 if par_drive=0. So with par_drive=1, par_pin_i=0 checks even parity and par_pin_i=1 checks odd parity. err_oe=1 (pulling low) means error register=1 and out_off=0. err_o is always 0.
- R6: On an edge where din[10]=0 and rst=0, the error register keeps its value.
- R7: With par_drive=0, par_pin_oe=1 and par_pin_o = ^D ^ par_in, where D is the word sampled at the last edge. With par_drive=1, par_pin_oe=0.
- R8: On an edge with rst=1, the holding register and the parity data delay clear to 0, and the error register clears to no-error (err_oe=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| buf_mode | input | 1 | 1 = buffer path, 0 = register path |
| hold_low | input | 1 | 1 = low eight register bits keep their value |
| out_off | input | 1 | 1 = release data and error outputs |
| din | input | 12 | Input word; bit 10 also gates error register loading |
| par_in | input | 1 | Parity bit for the word of the previous cycle |
| par_drive | input | 1 | 0 = drive partial sum on the parity pin, 1 = read the pin |
| par_pin_i | input | 1 | Value read from the parity pin |
| par_pin_o | output | 1 | Partial sum driven on the parity pin |
| par_pin_oe | output | 1 | Drive enable for the parity pin |
| ya | output | 12 | First output bank value |
| yb | output | 12 | Second output bank value |
| y_oe | output | 1 | Drive enable for both banks |
| err_o | output | 1 | Open-drain error value (always 0) |
| err_oe | output | 1 | Error pull-low enable |

## Verification
A corrupted holding register shows on both banks in the first register-mode cycle after the faulty edge. A bad hold field shows as low bits that change, or upper bits that stop following the input, one edge after hold_low is applied. A wrong parity delay or sense shows on err_oe exactly two edges after the word. It can also show on the parity pin one edge after the word when the block drives it. A lost load gate shows as err_oe changing on an edge where bit 10 was low.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic {
    PATH_REG = 1'b0,
    PATH_BUF = 1'b1
  } path_e;
endpackage

// File: rtl/pbus_store.sv
module pbus_store #(
  parameter int W     = 12,
  parameter int GATED = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_low,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  localparam int HI_W = W - GATED;

  generate
    if (GATED > 0) begin : g_low
      logic [GATED-1:0] lo_q;
      always_ff @(posedge clk) begin
        if (rst)
          lo_q <= '0;
        else if (!hold_low)
          lo_q <= din[GATED-1:0];
      end
      assign q[GATED-1:0] = lo_q;
    end
    if (HI_W > 0) begin : g_high
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst)
          hi_q <= '0;
        else
          hi_q <= din[W-1:GATED];
      end
      assign q[W-1:GATED] = hi_q;
    end
  endgenerate
endmodule

// File: rtl/pbus_parity.sv
module pbus_parity #(
  parameter int W      = 12,
  parameter int EN_BIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         par_in,
  input  logic         par_drive,
  input  logic         par_pin_i,
  output logic         par_pin_o,
  output logic         par_pin_oe,
  output logic         err_q
);
  logic [W-1:0] data_d;
  logic         partial;
  logic         ref_bit;
  logic         err_next;

  always_ff @(posedge clk) begin
    if (rst)
      data_d <= '0;
    else
      data_d <= din;
  end

  always_comb begin
    partial  = (^data_d) ^ par_in;
    ref_bit  = par_drive ? par_pin_i : 1'b0;
    err_next = partial ^ ref_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)
      err_q <= 1'b0;
    else if (din[EN_BIT])
      err_q <= err_next;
  end

  assign par_pin_o  = partial;
  assign par_pin_oe = ~par_drive;
endmodule

// File: rtl/pbus_outmux.sv
module pbus_outmux
  import pbus_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         buf_mode,
  input  logic         out_off,
  input  logic [W-1:0] din,
  input  logic [W-1:0] q,
  input  logic         err_q,
  output logic [W-1:0] ya,
  output logic [W-1:0] yb,
  output logic         y_oe,
  output logic         err_o,
  output logic         err_oe
);
  path_e path;
  assign path = path_e'(buf_mode);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic sel;
    assign sel   = (path == PATH_BUF) ? din[i] : q[i];
    assign ya[i] = sel;
    assign yb[i] = sel;
  end

  assign y_oe   = ~out_off;
  assign err_o  = 1'b0;
  assign err_oe = err_q & ~out_off;
endmodule

// File: rtl/pbus_drv.sv
module pbus_drv #(
  parameter int W      = 12,
  parameter int GATED  = 8,
  parameter int EN_BIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buf_mode,
  input  logic         hold_low,
  input  logic         out_off,
  input  logic [W-1:0] din,
  input  logic         par_in,
  input  logic         par_drive,
  input  logic         par_pin_i,
  output logic         par_pin_o,
  output logic         par_pin_oe,
  output logic [W-1:0] ya,
  output logic [W-1:0] yb,
  output logic         y_oe,
  output logic         err_o,
  output logic         err_oe
);
  logic [W-1:0] reg_q;
  logic         err_q;

  pbus_store #(.W(W), .GATED(GATED)) u_store (
    .clk(clk), .rst(rst), .hold_low(hold_low), .din(din), .q(reg_q)
  );

  pbus_parity #(.W(W), .EN_BIT(EN_BIT)) u_parity (
    .clk(clk), .rst(rst), .din(din), .par_in(par_in),
    .par_drive(par_drive), .par_pin_i(par_pin_i),
    .par_pin_o(par_pin_o), .par_pin_oe(par_pin_oe), .err_q(err_q)
  );

  pbus_outmux #(.W(W)) u_out (
    .buf_mode(buf_mode), .out_off(out_off), .din(din), .q(reg_q),
    .err_q(err_q), .ya(ya), .yb(yb), .y_oe(y_oe), .err_o(err_o),
    .err_oe(err_oe)
  );
endmodule

// File: rtl/pbus_drv_chk.sv
module pbus_drv_chk #(
  parameter int W      = 12,
  parameter int GATED  = 8,
  parameter int EN_BIT = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         buf_mode,
  input logic         hold_low,
  input logic         out_off,
  input logic [W-1:0] din,
  input logic         par_in,
  input logic         par_drive,
  input logic         par_pin_i,
  input logic         par_pin_o,
  input logic         par_pin_oe,
  input logic [W-1:0] ya,
  input logic         err_oe
);
  logic [1:0] edges = 2'd0;
  always_ff @(posedge clk)
    if (edges != 2'd3) edges <= edges + 2'd1;

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (rst)
    (edges >= 2'd1 && !buf_mode && !$past(hold_low) && !$past(rst))
      |-> ya == $past(din));

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (edges >= 2'd1 && !buf_mode && !$past(buf_mode) && $past(hold_low) && !$past(rst))
      |-> (ya[GATED-1:0] == $past(ya[GATED-1:0]) && ya[W-1:GATED] == $past(din[W-1:GATED])));

  // R5
  parity_err_chk: assert property (@(posedge clk) disable iff (rst)
    (edges >= 2'd2 && $past(din[EN_BIT]) && !$past(rst) && !$past(rst, 2) && !out_off)
      |-> err_oe == ((^$past(din, 2)) ^ $past(par_in) ^ ($past(par_drive) ? $past(par_pin_i) : 1'b0)));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (edges >= 2'd1 && !$past(din[EN_BIT]) && !$past(rst) && !out_off && !$past(out_off))
      |-> $stable(err_oe));

  // R7
  cascade_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (edges >= 2'd1 && par_pin_oe && !$past(rst))
      |-> par_pin_o == ((^$past(din)) ^ par_in));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (edges >= 2'd1 && $past(rst)) |-> (!err_oe && (buf_mode || ya == '0)));
endmodule

bind pbus_drv pbus_drv_chk #(.W(W), .GATED(GATED), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst(rst), .buf_mode(buf_mode), .hold_low(hold_low),
  .out_off(out_off), .din(din), .par_in(par_in), .par_drive(par_drive),
  .par_pin_i(par_pin_i), .par_pin_o(par_pin_o), .par_pin_oe(par_pin_oe),
  .ya(ya), .err_oe(err_oe)
);

// File: tb/pbus_drv_tb.sv
`timescale 1ns/100ps
module pbus_drv_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, buf_mode = 1'b0, hold_low = 1'b0, out_off = 1'b0;
  logic [11:0] din = '0;
  logic        par_in = 1'b0, par_drive = 1'b1, par_pin_i = 1'b0;
  logic        par_pin_o, par_pin_oe, y_oe, err_o, err_oe;
  logic [11:0] ya, yb;

  pbus_drv u_dut (
    .clk(clk), .rst(rst), .buf_mode(buf_mode), .hold_low(hold_low),
    .out_off(out_off), .din(din), .par_in(par_in), .par_drive(par_drive),
    .par_pin_i(par_pin_i), .par_pin_o(par_pin_o), .par_pin_oe(par_pin_oe),
    .ya(ya), .yb(yb), .y_oe(y_oe), .err_o(err_o), .err_oe(err_oe)
  );

  int checks = 0, errors = 0;

  // model state and inputs applied in the current cycle
  logic [11:0] m_reg = '0, m_dd = '0;
  logic        m_err = 1'b0;
  logic        c_rst = 1'b1, c_hold = 1'b0, c_par = 1'b0, c_drv = 1'b1, c_pin = 1'b0;
  logic [11:0] c_din = '0;

  // {buf_mode, hold_low, par_in, par_pin_i, din[11:0]}
  localparam logic [15:0] VEC [16] = '{
    16'h05A3, 16'h2FFF, 16'h4123, 16'h6C0F, 16'h1400, 16'h37FE, 16'h0000, 16'h8ABC,
    16'hA555, 16'hC0F0, 16'h13C3, 16'h5BEE, 16'h0FFF, 16'h7401, 16'h9E10, 16'h26A5
  };

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic rs, input logic md, input logic hd, input logic off,
                     input logic pr, input logic drv, input logic pin, input logic [11:0] d);
    string ytag, etag;
    @(negedge clk);
    ytag = c_rst ? "R8 bank" : (c_hold ? "R3 bank" : "R2 bank");
    etag = c_rst ? "R8 err" : (c_din[10] ? "R5 err" : "R6 err");
    if (c_rst) begin
      m_reg = '0; m_dd = '0; m_err = 1'b0;
    end else begin
      if (c_din[10]) m_err = (^m_dd) ^ c_par ^ (c_drv ? c_pin : 1'b0);
      m_dd = c_din;
      m_reg[11:8] = c_din[11:8];
      if (!c_hold) m_reg[7:0] = c_din[7:0];
    end
    rst = rs; buf_mode = md; hold_low = hd; out_off = off;
    par_in = pr; par_drive = drv; par_pin_i = pin; din = d;
    c_rst = rs; c_hold = hd; c_par = pr; c_drv = drv; c_pin = pin; c_din = d;
    #1;
    if (md) ytag = "R1 bank";
    if (!off) begin
      chk({ytag, " ya"}, ya, md ? d : m_reg);
      chk({ytag, " yb"}, yb, md ? d : m_reg);
      chk(etag, {11'd0, err_oe}, {11'd0, m_err});
    end else begin
      chk("R4 y_oe", {11'd0, y_oe}, 12'd0);
      chk("R4 err_oe", {11'd0, err_oe}, 12'd0);
    end
    chk("R5 err_o", {11'd0, err_o}, 12'd0);
    chk("R7 par_pin_oe", {11'd0, par_pin_oe}, {11'd0, ~drv});
    if (!drv) chk("R7 par_pin_o", {11'd0, par_pin_o}, {11'd0, (^m_dd) ^ pr});
  endtask

  initial begin
    // R8: reset state
    cyc(1, 0, 0, 0, 0, 1, 0, 12'hFFF);
    cyc(1, 0, 0, 0, 0, 1, 0, 12'hFFF);
    cyc(0, 0, 0, 0, 0, 1, 0, 12'h7FF);
    // table walk: R1 R2 R3 R5 R6
    for (int i = 0; i < 16; i++)
      cyc(0, VEC[i][15], VEC[i][14], 1'b0, VEC[i][13], 1'b1, VEC[i][12], VEC[i][11:0]);
    // R4: outputs off while registers still load and an error is captured
    cyc(0, 0, 0, 0, 0, 1, 0, 12'h001);
    cyc(0, 0, 0, 1, 0, 1, 0, 12'h4AB);
    cyc(0, 0, 0, 1, 0, 1, 0, 12'h4AB);
    cyc(0, 0, 1, 0, 1, 1, 0, 12'h0F0);
    cyc(0, 0, 1, 0, 0, 1, 0, 12'h0F0);
    // R7: cascade head drives its partial sum and checks even
    cyc(0, 0, 0, 0, 1, 0, 1, 12'h403);
    cyc(0, 1, 0, 0, 0, 0, 1, 12'h407);
    cyc(0, 0, 0, 0, 1, 0, 0, 12'h400);
    cyc(0, 0, 0, 0, 0, 0, 1, 12'hC01);
    // R6: bit 10 low keeps a set error
    cyc(0, 0, 0, 0, 1, 1, 0, 12'h3FF);
    cyc(0, 0, 0, 0, 0, 1, 1, 12'h000);
    cyc(0, 0, 0, 0, 0, 1, 0, 12'h000);
    // R8: reset mid-run clears registers and error
    cyc(1, 0, 0, 0, 0, 1, 0, 12'hFFF);
    cyc(0, 0, 0, 0, 0, 1, 0, 12'h000);
    cyc(0, 0, 0, 0, 0, 1, 0, 12'h000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule